// File: doc/BRIEF.md
# Cascadable Codec Serial Frame Interpreter

This block sits behind the serial port of a codec and handles the framing for it. The codec can be chained with other codecs on one serial link. Every transfer is a 16-bit word. An incoming word arrives on a valid/ready stream, and each accepted beat counts as one input frame sync. The current operating mode decides what an accepted word means. It can be a control word that reads or writes a small register file. It can be data for the DAC register. It can be a control word meant for a device further down the chain, which is forwarded with its address reduced by one. The mode is set by bits 1:0 of register 0.

A divided frame clock paces the outgoing words. On each frame tick the block emits one output word on a valid/ready stream, and that word acts as the output frame sync. The word is one of three things: a pending forwarded word or read response, the current ADC sample, or, in serial loop-back, the last word received. A digital loop-back path copies the ADC sample into the DAC register on every tick.

Back-pressure rules:
- `rx_ready` falls after a word that needs an output slot is accepted, that is a forwarded word or a read response. It rises again at the next frame tick.
- `tx_valid` rises on a tick and holds `tx_data` stable until `tx_ready` is seen.
- A tick that arrives while a word is still unaccepted replaces that word.

Top module: `cascade_frame_core`

## Requirements
- R1: After reset, `tx_valid` is 0, `rx_ready` is 1 and `dac_out` is 0. Register 0 reads 0x10, which selects program mode (bits 1:0 = 00) and a device count of 1 (bits 6:4). All other registers read 0.
- R2: Control word layout:
  - bit 15: control/data flag
  - bit 14: 1 = write, 0 = read
  - bits 13:11: device address
  - bits 10:8: register index
  - bits 7:0: register data

  In program mode every accepted word is a control word. A write with device address 0 stores bits 7:0 into the indexed register.
- R3: A control word with a nonzero device address changes no register. It is emitted unchanged at the next frame tick except that its address field is reduced by one.
- R4: A read with device address 0 is answered at the next frame tick with the word {bits 15:8 of the request, contents of the indexed register}.
- R5: Data mode is register 0 bits 1:0 = 01. Every accepted word is DAC data, and no register can be written until reset. A frame shaped like a write to register 1 therefore leaves the frame rate unchanged.
- R6: In data mode the block counts accepted words. The DAC register loads only on every Nth word, where N is register 0 bits 6:4, and a value of 0 means 8. The count starts at 0 after reset.
- R7: Mixed mode is register 0 bits 1:0 = 11. A word with bit 15 = 0 loads {bits 14:0, 0} into `dac_out` on the handshake edge. A word with bit 15 = 1 is handled as a control word.
- R8: An ADC word emitted in mixed mode has bit 15 forced to 0. An ADC word emitted in data mode is unchanged.
- R9: While `enable` is high, frames are emitted every BASE_DIV >> rate clock cycles. The rate is register 1 bits 1:0, and it resets to 0.
- R10: While `enable` is low, no frame is emitted.
- R11: With digital loop-back on (register 0 bit 2), each frame tick loads `adc_in` into `dac_out`.
- R12: With serial loop-back on (register 0 bit 3), each frame tick emits the last accepted input word unchanged.
- R13: A write can clear loop-back bits 3:2 of register 0 only while mixed mode is active. Outside mixed mode a write can only set them.
- R14: `tx_valid` stays high with `tx_data` stable until `tx_ready` is seen. `rx_ready` is low from the acceptance of a forwarded or read word until the next frame tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Serial enable; runs the frame clock |
| rx_valid | input | 1 | Input word valid (input frame sync) |
| rx_ready | output | 1 | Input word can be accepted |
| rx_data | input | 16 | Input word |
| tx_valid | output | 1 | Output word valid (output frame sync) |
| tx_ready | input | 1 | Output word taken |
| tx_data | output | 16 | Output word |
| adc_in | input | 16 | Current ADC sample |
| dac_out | output | 16 | DAC data register |

## Verification
Results are due at fixed points relative to a stimulus:
- Register writes, DAC loads and the drop of `rx_ready` take effect on the handshake edge. The bench checks them at the falling edge right after that handshake.
- Forwarded words, read responses, loop-back words and ADC words are due on the first frame tick after the stimulus. The bench waits for `tx_valid` to rise and reads `tx_data` at that falling edge.
- The bench sends each stimulus just after a frame has been observed. A whole frame period therefore separates the stimulus from the tick it is checked against.
- Frame rate is measured as the number of falling edges between two `tx_valid` pulses.

// File: rtl/cfi_pkg.sv
package cfi_pkg;
  localparam int WORD_W  = 16;
  localparam int DADDR_W = 3;
  localparam int RIDX_W  = 3;
  localparam int RDAT_W  = 8;
  localparam int NREG    = 1 << RIDX_W;
  localparam int CNT_W   = 3;

  localparam int B_FLAG = 15;
  localparam int B_WR   = 14;
  localparam int B_DADR = 11;
  localparam int B_RIDX = 8;

  localparam logic [RDAT_W-1:0] MODE_REG_RESET = 8'h10;

  typedef enum logic [1:0] {MD_PROG, MD_DATA, MD_MIXED} mode_e;

  function automatic mode_e mode_of(input logic [1:0] sel);
    if (!sel[0]) return MD_PROG;
    if (sel[1]) return MD_MIXED;
    return MD_DATA;
  endfunction
endpackage

// File: rtl/cfi_rate_gen.sv
module cfi_rate_gen #(
  parameter int BASE_DIV = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic [1:0] rate,
  output logic       tick
);
  localparam int CNT_W = $clog2(BASE_DIV);
  logic [CNT_W-1:0] cnt, lim;

  assign lim  = CNT_W'((BASE_DIV >> rate) - 1);
  assign tick = enable && (cnt >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable || tick) cnt <= '0;
    else                           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cfi_regfile.sv
module cfi_regfile
  import cfi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RIDX_W-1:0] wr_idx,
  input  logic [RDAT_W-1:0] wr_data,
  input  logic [RIDX_W-1:0] rd_idx,
  output logic [RDAT_W-1:0] rd_data,
  output logic [1:0]        mode_sel,
  output logic              dlb,
  output logic              slb,
  output logic [CNT_W-1:0]  dev_count,
  output logic [1:0]        rate
);
  logic [RDAT_W-1:0] regs [NREG];
  logic              in_mixed, locked;

  assign in_mixed  = (regs[0][1:0] == 2'b11);
  assign locked    = (mode_of(regs[0][1:0]) == MD_DATA);
  assign mode_sel  = regs[0][1:0];
  assign dlb       = regs[0][2];
  assign slb       = regs[0][3];
  assign dev_count = regs[0][6:4];
  assign rate      = regs[1][1:0];
  assign rd_data   = regs[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) regs[0] <= MODE_REG_RESET;
    else if (wr_en && wr_idx == '0) begin
      regs[0]      <= wr_data;
      regs[0][3:2] <= in_mixed ? wr_data[3:2] : (regs[0][3:2] | wr_data[3:2]);
    end
  end

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) regs[i] <= '0;
      else if (wr_en && wr_idx == RIDX_W'(i)) regs[i] <= wr_data;
    end
  end

  AST_LOCKED_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(regs[0]) && $stable(regs[1])); // R5
endmodule

// File: rtl/cfi_rx_decode.sv
module cfi_rx_decode
  import cfi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [WORD_W-1:0] data,
  input  mode_e             mode,
  input  logic [CNT_W-1:0]  dev_count,
  input  logic              dlb,
  output logic              reg_wr,
  output logic              rsp_req,
  output logic              fwd_req,
  output logic [WORD_W-1:0] fwd_word,
  output logic              dac_load,
  output logic              mixed_load,
  output logic [WORD_W-1:0] dac_word
);
  logic [DADDR_W-1:0] daddr;
  logic               is_ctrl, is_data, mine, last;
  logic [CNT_W-1:0]   fcnt;
  logic [CNT_W:0]     target;

  assign daddr   = data[B_DADR +: DADDR_W];
  assign mine    = (daddr == '0);
  assign is_ctrl = (mode == MD_PROG) || (mode == MD_MIXED && data[B_FLAG]);
  assign is_data = (mode == MD_DATA) || (mode == MD_MIXED && !data[B_FLAG]);
  assign target  = (dev_count == '0) ? (CNT_W+1)'(1 << CNT_W) : {1'b0, dev_count};
  assign last    = ({1'b0, fcnt} + 1'b1) == target;

  assign reg_wr   = fire && is_ctrl && mine && data[B_WR];
  assign rsp_req  = fire && is_ctrl && mine && !data[B_WR];
  assign fwd_req  = fire && is_ctrl && !mine;
  assign fwd_word = {data[WORD_W-1:B_DADR+DADDR_W], daddr - 1'b1, data[B_DADR-1:0]};

  assign dac_load   = fire && is_data && last && !dlb;
  assign mixed_load = dac_load && (mode == MD_MIXED);
  assign dac_word   = (mode == MD_MIXED) ? {data[WORD_W-2:0], 1'b0} : data;

  always_ff @(posedge clk) begin
    if (!rst_n)                fcnt <= '0;
    else if (fire && is_data)  fcnt <= last ? '0 : fcnt + 1'b1;
  end
endmodule

// File: rtl/cascade_frame_core.sv
module cascade_frame_core
  import cfi_pkg::*;
#(
  parameter int BASE_DIV = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [WORD_W-1:0] rx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [WORD_W-1:0] tx_data,
  input  logic [WORD_W-1:0] adc_in,
  output logic [WORD_W-1:0] dac_out
);
  logic              fire, tick, dlb, slb;
  logic              reg_wr, rsp_req, fwd_req, dac_load, mixed_load;
  logic [1:0]        mode_sel, rate;
  logic [CNT_W-1:0]  dev_count;
  logic [RDAT_W-1:0] rd_data;
  logic [WORD_W-1:0] fwd_word, dac_word, slb_word, pend_word, adc_word;
  logic              pend_q;
  mode_e             mode;

  assign fire     = rx_valid && rx_ready;
  assign rx_ready = !pend_q;
  assign mode     = mode_of(mode_sel);
  assign adc_word = (mode == MD_MIXED) ? {1'b0, adc_in[WORD_W-2:0]} : adc_in;

  cfi_rate_gen #(.BASE_DIV(BASE_DIV)) u_rate (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rate(rate), .tick(tick));

  cfi_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr),
    .wr_idx(rx_data[B_RIDX +: RIDX_W]), .wr_data(rx_data[RDAT_W-1:0]),
    .rd_idx(rx_data[B_RIDX +: RIDX_W]), .rd_data(rd_data),
    .mode_sel(mode_sel), .dlb(dlb), .slb(slb), .dev_count(dev_count), .rate(rate));

  cfi_rx_decode u_dec (
    .clk(clk), .rst_n(rst_n), .fire(fire), .data(rx_data), .mode(mode),
    .dev_count(dev_count), .dlb(dlb), .reg_wr(reg_wr), .rsp_req(rsp_req),
    .fwd_req(fwd_req), .fwd_word(fwd_word), .dac_load(dac_load),
    .mixed_load(mixed_load), .dac_word(dac_word));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      pend_word <= '0;
      slb_word  <= '0;
    end else begin
      if (fire) slb_word <= rx_data;
      if (fwd_req || rsp_req) begin
        pend_q    <= 1'b1;
        pend_word <= fwd_req ? fwd_word : {rx_data[WORD_W-1:RDAT_W], rd_data};
      end else if (tick) begin
        pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (tick) begin
      tx_valid <= 1'b1;
      tx_data  <= slb ? slb_word : (pend_q ? pend_word : adc_word);
    end else if (tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            dac_out <= '0;
    else if (tick && dlb)  dac_out <= adc_in;
    else if (dac_load)     dac_out <= dac_word;
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !tick) |=> tx_valid && $stable(tx_data)); // R14
  AST_FWD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mode == MD_PROG && rx_data[B_DADR +: DADDR_W] != '0) |=> !rx_ready); // R3
  AST_IDLE_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !tx_valid) |=> !tx_valid); // R10
  AST_MIXED_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    mixed_load |=> !dac_out[0]); // R7
endmodule

// File: tb/cascade_frame_core_bench.sv
module cascade_frame_core_bench;
  logic        clk = 1'b0, rst_n = 1'b0, enable = 1'b1;
  logic        rx_valid = 1'b0, tx_ready = 1'b1;
  logic [15:0] rx_data = '0, adc_in = '0;
  logic        rx_ready, tx_valid;
  logic [15:0] tx_data, dac_out;
  int          n_chk = 0, n_bad = 0, cyc = 0;
  bit          timed_out = 1'b0;

  always #2 clk = ~clk;

  cascade_frame_core #(.BASE_DIV(64)) u_cascade_frame_core (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .adc_in(adc_in), .dac_out(dac_out));

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rx_valid = 1'b0; tx_ready = 1'b1; enable = 1'b1; adc_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w);
    int g = 0;
    @(negedge clk);
    while (!rx_ready && g < 5000) begin @(negedge clk); g++; end
    rx_data = w; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic wait_frame(output logic [15:0] w);
    int g = 0;
    while (tx_valid && g < 5000) begin @(negedge clk); g++; end
    while (!tx_valid && g < 5000) begin @(negedge clk); g++; end
    if (g >= 5000) begin n_chk++; n_bad++; $display("FAIL frame wait: actual none expected frame"); end
    w = tx_data;
  endtask

  task automatic period(output int p);
    logic [15:0] w;
    wait_frame(w);
    p = 0;
    do begin @(negedge clk); p++; end while (!tx_valid && p < 5000);
  endtask

  task automatic t_reset();
    logic [15:0] w;
    do_reset();
    check("R1 tx_valid", 16'(tx_valid), 16'd0);
    check("R1 rx_ready", 16'(rx_ready), 16'd1);
    check("R1 dac_out", dac_out, 16'h0000);
    send(16'h0000);
    wait_frame(w);
    check("R1 R4 read reg0", w, 16'h0010);
  endtask

  task automatic t_write_read();
    logic [15:0] w;
    do_reset();
    send(16'h45A5);
    send(16'h0500);
    wait_frame(w);
    check("R2 R4 reg5 readback", w, 16'h05A5);
  endtask

  task automatic t_forward();
    logic [15:0] w;
    do_reset();
    send(16'h5A33);
    check("R14 rx_ready low after forward", 16'(rx_ready), 16'd0);
    wait_frame(w);
    check("R3 forwarded word", w, 16'h5233);
    send(16'h0200);
    wait_frame(w);
    check("R3 reg2 untouched", w, 16'h0200);
  endtask

  task automatic t_rate();
    logic [15:0] w;
    int p;
    do_reset();
    period(p);
    check("R9 default period", 16'(p), 16'd64);
    send(16'h4102);
    wait_frame(w);
    period(p);
    check("R9 rate 2 period", 16'(p), 16'd16);
  endtask

  task automatic t_enable();
    int seen = 0;
    do_reset();
    enable = 1'b0;
    repeat (300) begin @(negedge clk); if (tx_valid) seen++; end
    check("R10 no frames when disabled", 16'(seen), 16'd0);
    enable = 1'b1;
  endtask

  task automatic t_data_mode();
    logic [15:0] w;
    int p;
    do_reset();
    send(16'h4011);
    send(16'h1234);
    check("R5 data load", dac_out, 16'h1234);
    send(16'h4102);
    check("R5 ctrl-shaped data load", dac_out, 16'h4102);
    period(p);
    check("R5 rate unchanged", 16'(p), 16'd64);
    adc_in = 16'hF00D;
    wait_frame(w);
    check("R8 data mode adc word", w, 16'hF00D);
  endtask

  task automatic t_dev_count();
    do_reset();
    send(16'h4031);
    send(16'hAAAA);
    check("R6 frame 1 skipped", dac_out, 16'h0000);
    send(16'hBBBB);
    check("R6 frame 2 skipped", dac_out, 16'h0000);
    send(16'hCCCC);
    check("R6 frame 3 loaded", dac_out, 16'hCCCC);
    send(16'hDDDD);
    check("R6 frame 4 skipped", dac_out, 16'hCCCC);
  endtask

  task automatic t_mixed();
    logic [15:0] w;
    int p;
    do_reset();
    send(16'h4013);
    send(16'h1234);
    check("R7 mixed data justified", dac_out, 16'h2468);
    send(16'hC105);
    check("R7 ctrl frame no dac load", dac_out, 16'h2468);
    adc_in = 16'hFFFF;
    wait_frame(w);
    period(p);
    check("R7 R9 mixed ctrl set rate 1", 16'(p), 16'd32);
    check("R8 mixed adc msb cleared", tx_data, 16'h7FFF);
  endtask

  task automatic t_dlb();
    logic [15:0] w;
    do_reset();
    send(16'h4014);
    adc_in = 16'h0BEE;
    wait_frame(w);
    check("R11 loop-back copy", dac_out, 16'h0BEE);
    send(16'h4010);
    adc_in = 16'h0CAF;
    wait_frame(w);
    check("R13 program clear ignored", dac_out, 16'h0CAF);
    send(16'h4017);
    wait_frame(w);
    send(16'hC013);
    adc_in = 16'h0DAD;
    wait_frame(w);
    wait_frame(w);
    check("R13 mixed clear works", dac_out, 16'h0CAF);
  endtask

  task automatic t_slb();
    logic [15:0] w;
    do_reset();
    send(16'h4018);
    wait_frame(w);
    send(16'h7777);
    wait_frame(w);
    check("R12 serial loop-back word", w, 16'h7777);
  endtask

  task automatic t_backpressure();
    logic [15:0] w, held;
    do_reset();
    adc_in = 16'h5A5A;
    tx_ready = 1'b0;
    wait_frame(w);
    held = w;
    repeat (10) @(negedge clk);
    check("R14 valid held", 16'(tx_valid), 16'd1);
    check("R14 data held", tx_data, held);
    tx_ready = 1'b1;
    @(negedge clk);
    check("R14 valid drops after ready", 16'(tx_valid), 16'd0);
  endtask

  initial begin
    t_reset();
    t_write_read();
    t_forward();
    t_rate();
    t_enable();
    t_data_mode();
    t_dev_count();
    t_mixed();
    t_dlb();
    t_slb();
    t_backpressure();
    if (!timed_out) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    wait (cyc >= 150000);
    timed_out = 1'b1;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule